// File: doc/BRIEF.md
# SPI Real-Time-Clock Register Slave

This block is the serial register front end of a small real-time clock. A host reaches it over a four-wire SPI link in mode 3: the clock idles high, input bits are sampled on rising SCK and output bits are driven on falling SCK, most significant bit first. The chip enable is active high. Each enable period begins with one command byte. Its top bit selects the direction (1 = write, 0 = read) and its low seven bits give the starting register. Every further byte in the same enable period reaches the next register up. The 7-bit address wraps from 0x7F to 0x00.

The block does not count time itself. The timekeeping core presents the live time as seven bytes on `tk_time_i`. The block copies them into a shadow when a read command arrives, so a burst read gives one coherent instant. A write to a time register is passed back to the core as a one-cycle load strobe, with the register index and the masked byte. Alarm, trickle-charge and user RAM bytes are held inside the block. The control byte and the trickle byte are also presented as outputs. Status is a read-only view of an input. A write-protect bit in the control byte freezes the time and alarm registers.

The SPI inputs pass through two-flop synchronisers into the `clk` domain. Each half period of SCK must therefore last at least four `clk` cycles.

Top module: `rtc_spi_regfile`

## Requirements
- R1: After reset, `spi_sdo_o`, `tk_load_o`, `ctrl_o` and `trickle_o` are all 0.
- R2: The first byte after enable rises is a command sampled on rising SCK, MSB first: bit 7 = 1 selects write, bit 7 = 0 selects read, and bits 6:0 give the start address.
- R3: In a read, each data byte is driven MSB first, each bit changing only after a falling SCK and holding until the next falling SCK.
- R4: Each data byte after the command moves the address up by one, in both directions, and the address wraps from 0x7F to 0x00.
- R5: An accepted write to address 0x00–0x06 gives a one-cycle `tk_load_o` pulse with `tk_load_sel_o` equal to the address. The data is masked by address: seconds (0) 0x7F, minutes (1) 0x7F, hours (2) 0x7F, day-of-week (3) 0x07, date (4) 0x3F, month (5) 0x1F, year (6) 0xFF.
- R6: While control bit 6 is 1, writes to 0x00–0x0E have no effect (no load pulse, alarm bytes unchanged). Writes to the control register at 0x0F are always accepted.
- R7: A read of 0x00–0x06 returns the masked byte of a snapshot of `tk_time_i` (byte n in bits 8n+7:8n). The snapshot is taken when the read command completes, and later changes of `tk_time_i` in the same burst do not show.
- R8: Addresses 0x07–0x0E are eight read/write alarm bytes. 0x0F is control and drives `ctrl_o`. 0x11 is trickle-charge and drives `trickle_o`. 0x10 reads `stat_i`, and writes to it are ignored.
- R9: Addresses 0x12–0x1F read as 0x00, and writes to them change nothing.
- R10: While enable is low, `spi_sdo_o` is 0. A fall of enable discards any partial byte, and the next enable expects a new command.
- R11: Addresses 0x20–0x7F are 96 bytes of user RAM that read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_ce_i | input | 1 | Active-high chip enable |
| spi_sck_i | input | 1 | Serial clock, idle high |
| spi_sdi_i | input | 1 | Serial data into the block |
| spi_sdo_o | output | 1 | Serial data out of the block, 0 when idle |
| tk_time_i | input | 56 | Live time bytes from the timekeeping core, seconds in the low byte |
| tk_load_o | output | 1 | One-cycle strobe: load a time byte into the core |
| tk_load_sel_o | output | 3 | Index of the time byte to load |
| tk_load_data_o | output | 8 | Masked byte to load |
| stat_i | input | 8 | Value returned by the status register |
| ctrl_o | output | 8 | Control register contents (bit 6 = write protect) |
| trickle_o | output | 8 | Trickle-charge register contents |

## Verification
The bench sweeps the whole RAM window with an arithmetic pattern, written in one burst and read back in another. This shows that the address increments and that the bit order holds byte after byte. All-ones bytes written to the seven time registers show the per-register masks. A burst that starts at 0x7E shows the wrap into the time registers, in both directions. A snapshot taken before `tk_time_i` changes in mid-burst shows whether the shadow or the live bus feeds the data. The bench repeats alarm writes with write protect set and then cleared, and writes to the status register and to unused addresses. These separate writes that are ignored from writes that land. An enable dropped in the middle of a byte checks that the next command is framed afresh.

// File: rtl/rtc_spi_regfile.sv
module rtc_spi_regfile #(
  parameter int RAM_LO = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_ce_i,
  input  logic        spi_sck_i,
  input  logic        spi_sdi_i,
  output logic        spi_sdo_o,
  input  logic [55:0] tk_time_i,
  output logic        tk_load_o,
  output logic [2:0]  tk_load_sel_o,
  output logic [7:0]  tk_load_data_o,
  input  logic [7:0]  stat_i,
  output logic [7:0]  ctrl_o,
  output logic [7:0]  trickle_o
);
  localparam int RAM_N = 128 - RAM_LO;
  localparam logic [6:0] RAM_BASE = 7'(RAM_LO);

  logic [1:0] ce_p, sck_p, sdi_p;
  logic       sck_q;
  logic       ce_s, sck_s, sdi_s;
  logic       sck_rise, sck_fall;
  logic [2:0] bit_cnt;
  logic [6:0] shift_in;
  logic [7:0] rx_byte;
  logic       have_addr, is_wr;
  logic [6:0] addr;
  logic [7:0] tx_sh;
  logic [55:0] shadow;
  logic [7:0] alarm [8];
  logic [7:0] ram [RAM_N];
  logic [7:0] rdata;
  logic [6:0] ram_idx, al_idx;
  logic       byte_done, wr_stb, wp;

  assign ce_s  = ce_p[1];
  assign sck_s = sck_p[1];
  assign sdi_s = sdi_p[1];
  assign sck_rise = ce_s & sck_s & ~sck_q;
  assign sck_fall = ce_s & ~sck_s & sck_q;
  assign rx_byte  = {shift_in, sdi_s};
  assign byte_done = sck_rise && bit_cnt == 3'd7;
  assign wr_stb   = byte_done && have_addr && is_wr;
  assign wp       = ctrl_o[6];
  assign ram_idx  = addr - RAM_BASE;
  assign al_idx   = addr - 7'd7;

  function automatic logic [7:0] tmask(input logic [2:0] i);
    case (i)
      3'd3:    return 8'h07;
      3'd4:    return 8'h3F;
      3'd5:    return 8'h1F;
      3'd6:    return 8'hFF;
      default: return 8'h7F;
    endcase
  endfunction

  always_comb begin
    rdata = 8'h00;
    if (addr < 7'd7)
      rdata = shadow[{addr[2:0], 3'b000} +: 8] & tmask(addr[2:0]);
    else if (addr < 7'd15)
      rdata = alarm[al_idx[2:0]];
    else if (addr == 7'd15)
      rdata = ctrl_o;
    else if (addr == 7'd16)
      rdata = stat_i;
    else if (addr == 7'd17)
      rdata = trickle_o;
    else if (addr >= RAM_BASE)
      rdata = ram[ram_idx];
  end

  always_ff @(posedge clk) begin
    if (wr_stb && addr >= RAM_BASE)
      ram[ram_idx] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_p <= 2'b00;
      sck_p <= 2'b11;
      sdi_p <= 2'b00;
      sck_q <= 1'b1;
      bit_cnt <= '0;
      shift_in <= '0;
      have_addr <= 1'b0;
      is_wr <= 1'b0;
      addr <= '0;
      tx_sh <= '0;
      shadow <= '0;
      spi_sdo_o <= 1'b0;
      tk_load_o <= 1'b0;
      tk_load_sel_o <= '0;
      tk_load_data_o <= '0;
      ctrl_o <= '0;
      trickle_o <= '0;
      for (int i = 0; i < 8; i++) alarm[i] <= '0;
    end else begin
      ce_p  <= {ce_p[0], spi_ce_i};
      sck_p <= {sck_p[0], spi_sck_i};
      sdi_p <= {sdi_p[0], spi_sdi_i};
      sck_q <= sck_s;
      tk_load_o <= 1'b0;
      if (!ce_s) begin
        have_addr <= 1'b0;
        bit_cnt <= '0;
        spi_sdo_o <= 1'b0;
      end else begin
        if (sck_rise) begin
          shift_in <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done) begin
          if (!have_addr) begin
            have_addr <= 1'b1;
            is_wr <= rx_byte[7];
            addr <= rx_byte[6:0];
            if (!rx_byte[7]) shadow <= tk_time_i;
          end else begin
            addr <= addr + 7'd1;
          end
        end
        if (wr_stb) begin
          if (addr < 7'd7) begin
            if (!wp) begin
              tk_load_o <= 1'b1;
              tk_load_sel_o <= addr[2:0];
              tk_load_data_o <= rx_byte & tmask(addr[2:0]);
            end
          end else if (addr < 7'd15) begin
            if (!wp) alarm[al_idx[2:0]] <= rx_byte;
          end else if (addr == 7'd15) begin
            ctrl_o <= rx_byte;
          end else if (addr == 7'd17) begin
            trickle_o <= rx_byte;
          end
        end
        if (sck_fall && have_addr && !is_wr) begin
          if (bit_cnt == 3'd0) begin
            spi_sdo_o <= rdata[7];
            tx_sh <= {rdata[6:0], 1'b0};
          end else begin
            spi_sdo_o <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_spi_regfile_chk.sv
module rtc_spi_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_s,
  input logic       sck_fall,
  input logic       spi_sdo_o,
  input logic       tk_load_o,
  input logic [2:0] tk_load_sel_o,
  input logic [7:0] tk_load_data_o,
  input logic [7:0] ctrl_o
);
  // R10
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !spi_sdo_o);

  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce_s) && !$past(sck_fall)) |-> $stable(spi_sdo_o));

  // R5
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tk_load_o |=> !tk_load_o);

  // R5
  load_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tk_load_o |-> tk_load_sel_o <= 3'd6);

  // R5
  load_dow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tk_load_o && tk_load_sel_o == 3'd3) |-> tk_load_data_o[7:3] == 5'd0);

  // R6
  load_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tk_load_o |-> !$past(ctrl_o[6]));
endmodule

bind rtc_spi_regfile rtc_spi_regfile_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ce_s(ce_s),
  .sck_fall(sck_fall),
  .spi_sdo_o(spi_sdo_o),
  .tk_load_o(tk_load_o),
  .tk_load_sel_o(tk_load_sel_o),
  .tk_load_data_o(tk_load_data_o),
  .ctrl_o(ctrl_o)
);

// File: tb/tb_rtc_spi_regfile.sv
module tb_rtc_spi_regfile;
  localparam int H = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, sck = 1'b1, sdi = 1'b0;
  logic        sdo;
  logic [55:0] tk_time = '0;
  logic        tk_load;
  logic [2:0]  tk_sel;
  logic [7:0]  tk_data;
  logic [7:0]  stat = 8'h00;
  logic [7:0]  ctrl, trickle;

  int n_chk = 0, n_fail = 0;
  int load_cnt = 0;
  logic [2:0] last_sel;
  logic [7:0] last_data;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_spi_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .spi_ce_i(ce), .spi_sck_i(sck), .spi_sdi_i(sdi), .spi_sdo_o(sdo),
    .tk_time_i(tk_time), .tk_load_o(tk_load), .tk_load_sel_o(tk_sel),
    .tk_load_data_o(tk_data), .stat_i(stat), .ctrl_o(ctrl), .trickle_o(trickle)
  );

  always @(posedge clk) if (tk_load) begin
    load_cnt <= load_cnt + 1;
    last_sel <= tk_sel;
    last_data <= tk_data;
  end

  function automatic logic [7:0] mask_of(input int i);
    if (i == 3) return 8'h07;
    if (i == 4) return 8'h3F;
    if (i == 5) return 8'h1F;
    if (i == 6) return 8'hFF;
    return 8'h7F;
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_tx();
    ce = 1'b1;
    wait_clk(H);
  endtask

  task automatic end_tx();
    wait_clk(H);
    ce = 1'b0;
    wait_clk(2 * H);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      sdi = tx[i];
      wait_clk(H);
      rx[i] = sdo;
      sck = 1'b1;
      wait_clk(H);
    end
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    begin_tx();
    xfer({1'b1, a}, r);
    xfer(d, r);
    end_tx();
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] r;
    begin_tx();
    xfer({1'b0, a}, r);
    xfer(8'h00, d);
    end_tx();
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, d;
    int lc;
    wait_clk(4);
    // R1 reset state
    chk(sdo == 0 && tk_load == 0, "R1 sdo/load", {sdo, tk_load}, 0);
    chk(ctrl == 8'h00, "R1 ctrl", ctrl, 0);
    chk(trickle == 8'h00, "R1 trickle", trickle, 0);
    rst_n = 1'b1;
    wait_clk(4);

    // R11 R2 R4 full RAM burst write then burst read
    begin_tx();
    xfer(8'h80 | 8'h20, r);
    for (int a = 32; a < 128; a++) xfer(pat(a), r);
    end_tx();
    begin_tx();
    xfer(8'h20, r);
    for (int a = 32; a < 128; a++) begin
      xfer(8'h00, d);
      chk(d == pat(a), "R11 R3 R4 ram burst", d, pat(a));
    end
    end_tx();

    // R10 sdo idle between transactions
    chk(sdo == 1'b0, "R10 sdo idle", sdo, 0);

    // R5 masks on all-ones burst to time registers
    lc = load_cnt;
    begin_tx();
    xfer(8'h80, r);
    for (int i = 0; i < 7; i++) begin
      xfer(8'hFF, r);
      wait_clk(1);
      chk(load_cnt == lc + i + 1, "R5 load count", load_cnt, lc + i + 1);
      chk(last_sel == 3'(i), "R5 load sel", last_sel, i);
      chk(last_data == mask_of(i), "R5 load mask", last_data, mask_of(i));
    end
    end_tx();

    // R4 wrap write 0x7E,0x7F then seconds
    lc = load_cnt;
    begin_tx();
    xfer(8'hFE, r);
    xfer(8'h11, r);
    xfer(8'h22, r);
    xfer(8'hB3, r);
    end_tx();
    chk(load_cnt == lc + 1, "R4 wrap load count", load_cnt, lc + 1);
    chk(last_sel == 3'd0 && last_data == 8'h33, "R4 wrap into seconds", last_data, 8'h33);

    // R7 snapshot and R4 read wrap
    tk_time = 56'h99_F2_F1_FB_E5_FF_D9;
    begin_tx();
    xfer(8'h7F, r);
    tk_time = 56'h01_01_01_01_01_01_01;
    xfer(8'h00, d);
    chk(d == 8'h22, "R4 read wrap ram7F", d, 8'h22);
    for (int i = 0; i < 7; i++) begin
      logic [7:0] e;
      e = 8'(56'h99_F2_F1_FB_E5_FF_D9 >> (8 * i)) & mask_of(i);
      xfer(8'h00, d);
      chk(d == e, "R7 snapshot masked", d, e);
    end
    end_tx();
    rd1(7'h00, d);
    chk(d == 8'h01, "R7 new snapshot", d, 8'h01);

    // R8 alarms, trickle, status
    for (int a = 7; a < 15; a++) wr1(7'(a), 8'(a * 17));
    for (int a = 7; a < 15; a++) begin
      rd1(7'(a), d);
      chk(d == 8'(a * 17), "R8 alarm", d, 8'(a * 17));
    end
    wr1(7'h11, 8'hC6);
    chk(trickle == 8'hC6, "R8 trickle_o", trickle, 8'hC6);
    stat = 8'hA5;
    wr1(7'h10, 8'h3C);
    rd1(7'h10, d);
    chk(d == 8'hA5, "R8 status read-only", d, 8'hA5);

    // R6 write protect
    wr1(7'h0F, 8'h40);
    chk(ctrl == 8'h40, "R6 ctrl set", ctrl, 8'h40);
    lc = load_cnt;
    wr1(7'h02, 8'h12);
    wr1(7'h09, 8'hEE);
    chk(load_cnt == lc, "R6 no load when protected", load_cnt, lc);
    rd1(7'h09, d);
    chk(d == 8'(9 * 17), "R6 alarm held", d, 8'(9 * 17));
    wr1(7'h0F, 8'h00);
    chk(ctrl == 8'h00, "R6 ctrl cleared", ctrl, 0);
    wr1(7'h09, 8'hEE);
    rd1(7'h09, d);
    chk(d == 8'hEE, "R6 alarm after clear", d, 8'hEE);
    wr1(7'h02, 8'h92);
    chk(load_cnt == lc + 1 && last_data == 8'h12, "R6 R5 hours load", last_data, 8'h12);

    // R9 unimplemented
    wr1(7'h15, 8'h77);
    for (int a = 18; a < 32; a++) begin
      rd1(7'(a), d);
      chk(d == 8'h00, "R9 unimplemented zero", d, 0);
    end

    // R10 partial byte then fresh command
    ce = 1'b1;
    wait_clk(H);
    for (int i = 0; i < 5; i++) begin
      sck = 1'b0; sdi = 1'b1; wait_clk(H);
      sck = 1'b1; wait_clk(H);
    end
    ce = 1'b0;
    wait_clk(2 * H);
    chk(sdo == 1'b0, "R10 sdo low after abort", sdo, 0);
    wr1(7'h25, 8'h5A);
    rd1(7'h25, d);
    chk(d == 8'h5A, "R10 R2 fresh command", d, 8'h5A);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule